// File: doc/BRIEF.md
# Configurable Test Pattern Generator

This block supplies the data words for a memory or register test. A single instance holds the state for nine pattern families: fixed zeros, fixed ones, a user constant, a walking one, a walking zero, a pseudo-random sequence, an incrementing count, ones alternating with zeros, and a constant alternating with its complement. A mode select picks which family drives the output word. The word is a plain function of the selected mode, the constant input and internal state. It changes only when an init or advance strobe arrives, or when the mode or constant input changes.

The test sequencer pulses the init strobe to start a run and pulses the advance strobe once per iteration after it has consumed the current word. The advance strobe is the consumer's request for the next word, so no valid/ready handshake is used and there is no back-pressure: the word is always valid and is held until the next strobe. Comparing read-back data and stepping addresses are handled by other blocks.

Top module: `test_pattern_gen`

## Requirements
- R1: After reset, and in the cycle after an init strobe, the generators hold their start state. The walking one is 1. The walking zero is all ones except bit 0. The count is 0. Both alternating modes are in their first phase, which is all ones or the constant. The pseudo-random state is the seed after an init, and 1 after reset.
- R2: The mode encoding is: 0 zeros, 1 ones, 2 constant, 3 walking one, 4 walking zero, 5 pseudo-random, 6 count, 7 ones/zeros alternation, 8 constant/complement alternation. Codes 9 to 15 output all zeros. The constant mode follows `const_i` in the same cycle.
- R3: When no init or advance strobe is present and the mode and constant inputs do not change, the output word does not change on the next clock edge.
- R4: In walking-one mode, each advance shifts the single 1 one place toward the most significant bit. The advance after the 1 reaches bit W-1 returns it to bit 0, giving a period of W.
- R5: Walking-zero mode is the bitwise complement of walking-one mode and has the same shift and return rule.
- R6: Pseudo-random mode is a maximal-length LFSR loaded from `seed_i` on init. It never outputs zero and repeats after exactly 2^W-1 advances. An all-zero seed is replaced by the value 1.
- R7: Count mode adds 1 on each advance and wraps from all ones to 0.
- R8: The ones/zeros alternation mode starts with all ones and inverts the word on each advance.
- R9: The constant/complement alternation mode outputs `const_i` in its first phase and ~`const_i` in the other, and switches phase on each advance.
- R10: Every generator advances on every advance strobe, whichever mode is selected. An init strobe overrides an advance strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Pattern mode select (encoding in R2) |
| const_i | input | W | User constant |
| seed_i | input | W | Pseudo-random seed, loaded on init |
| init_i | input | 1 | Return all generators to their start state |
| adv_i | input | 1 | Step all generators to the next word |
| word_o | output | W | Current pattern word |

## Verification
The bench uses an 8-bit instance. It runs the walking modes through more than two full periods, so a design that shifted the marker out and left the word at zero, or reloaded it one position off, would produce a wrong word at the wrap. The count is stepped through its full range and past it, which catches a counter that saturates or is too wide. The pseudo-random sequence is run for a complete cycle and must return to its seed at exactly 255 advances with no repeats and no zero word; a feedback polynomial that is not maximal would return early, and a design that passes a zero seed through would lock at zero. The bench also advances while another mode is selected and applies init together with advance, which exposes generators gated by mode and the wrong strobe priority.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    PAT_ZERO      = 4'd0,
    PAT_ONES      = 4'd1,
    PAT_CONST     = 4'd2,
    PAT_WALK1     = 4'd3,
    PAT_WALK0     = 4'd4,
    PAT_PRNG      = 4'd5,
    PAT_COUNT     = 4'd6,
    PAT_ALT_ONES  = 4'd7,
    PAT_ALT_CONST = 4'd8
  } pat_mode_e;

  // Fibonacci feedback taps: bit k-1 set for each x^k term of a primitive
  // polynomial of degree w. Zero means the width has no entry.
  function automatic logic [63:0] lfsr_taps(input int w);
    case (w)
      3:       return 64'h6;
      4:       return 64'hC;
      5:       return 64'h14;
      6:       return 64'h30;
      7:       return 64'h60;
      8:       return 64'hB8;
      9:       return 64'h110;
      10:      return 64'h240;
      11:      return 64'h500;
      12:      return 64'hE08;
      13:      return 64'h1C80;
      14:      return 64'h3802;
      15:      return 64'h6000;
      16:      return 64'hD008;
      17:      return 64'h12000;
      18:      return 64'h20400;
      19:      return 64'h72000;
      20:      return 64'h90000;
      24:      return 64'hE10000;
      32:      return 64'h80200003;
      default: return 64'h0;
    endcase
  endfunction

endpackage

// File: rtl/tpg_walker.sv
module tpg_walker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         adv_i,
  output logic [W-1:0] marker_o
);

  localparam logic [W-1:0] FIRST = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] marker_q;

  // Rotation left: the bit leaving position W-1 re-enters at position 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      marker_q <= FIRST;
    else if (init_i) marker_q <= FIRST;
    else if (adv_i)  marker_q <= {marker_q[W-2:0], marker_q[W-1]};
  end

  assign marker_o = marker_q;

  a_r4_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(marker_q));

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         adv_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);

  localparam logic [63:0]  TAPS_FULL = tpg_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];
  localparam logic [W-1:0] FALLBACK  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q;
  logic [W-1:0] load_val;
  logic         feedback;

  assign load_val = (seed_i == '0) ? FALLBACK : seed_i;
  assign feedback = ^(state_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= FALLBACK;
    else if (init_i) state_q <= load_val;
    else if (adv_i)  state_q <= {state_q[W-2:0], feedback};
  end

  assign state_o = state_q;

  initial begin
    a_r6_width_has_taps: assert (TAPS != '0);
  end

  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  a_r6_zero_seed_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    init_i && seed_i == '0 |=> state_q == FALLBACK);

endmodule

// File: rtl/tpg_counter.sv
module tpg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         adv_i,
  output logic [W-1:0] count_o,
  output logic         phase_o
);

  logic [W-1:0] count_q;
  logic         phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      phase_q <= 1'b0;
    end else if (init_i) begin
      count_q <= '0;
      phase_q <= 1'b0;
    end else if (adv_i) begin
      count_q <= count_q + 1'b1;
      phase_q <= ~phase_q;
    end
  end

  assign count_o = count_q;
  assign phase_o = phase_q;

  a_r8_phase_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == count_q[0]);

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [tpg_pkg::MODE_W-1:0] mode_i,
  input  logic [W-1:0]              const_i,
  input  logic [W-1:0]              seed_i,
  input  logic                      init_i,
  input  logic                      adv_i,
  output logic [W-1:0]              word_o
);

  import tpg_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] marker;
  logic [W-1:0] prng;
  logic [W-1:0] count;
  logic         phase;

  tpg_walker #(.W(W)) walker_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .adv_i(adv_i),
    .marker_o(marker)
  );

  tpg_lfsr #(.W(W)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .adv_i(adv_i),
    .seed_i(seed_i), .state_o(prng)
  );

  tpg_counter #(.W(W)) counter_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .adv_i(adv_i),
    .count_o(count), .phase_o(phase)
  );

  always_comb begin
    case (mode_i)
      PAT_ZERO:      word_o = '0;
      PAT_ONES:      word_o = '1;
      PAT_CONST:     word_o = const_i;
      PAT_WALK1:     word_o = marker;
      PAT_WALK0:     word_o = ~marker;
      PAT_PRNG:      word_o = prng;
      PAT_COUNT:     word_o = count;
      PAT_ALT_ONES:  word_o = phase ? '0 : '1;
      PAT_ALT_CONST: word_o = phase ? ~const_i : const_i;
      default:       word_o = '0;
    endcase
  end

  a_r1_init_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (mode_i != PAT_COUNT) || (word_o == '0));

  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i && !init_i |=> !$stable(mode_i) || !$stable(const_i) || $stable(word_o));

  a_r4_walk_returns: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !init_i && mode_i == PAT_WALK1 && word_o[W-1]
    |=> (mode_i != PAT_WALK1) || (word_o == ONE));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !init_i && mode_i == PAT_COUNT
    |=> (mode_i != PAT_COUNT) || (word_o == $past(word_o) + 1'b1));

  a_r8_alt_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !init_i && mode_i == PAT_ALT_ONES
    |=> (mode_i != PAT_ALT_ONES) || (word_o == ~$past(word_o)));

endmodule

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb_top;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [3:0]   mode;
  logic [W-1:0] cval;
  logic [W-1:0] seed;
  logic         init;
  logic         adv;
  logic [W-1:0] word;

  int vectors = 0;
  int fails   = 0;

  test_pattern_gen #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .const_i(cval), .seed_i(seed),
    .init_i(init), .adv_i(adv), .word_o(word)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_init();
    init = 1'b1;
    step();
    init = 1'b0;
  endtask

  task automatic do_adv();
    adv = 1'b1;
    step();
    adv = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic seen [0:N-1];
    int   period;
    int   distinct;
    logic [W-1:0] hold;

    rst_n = 1'b0; mode = 4'd0; cval = '0; seed = '0; init = 1'b0; adv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state of each family
    mode = 4'd3; #1 chk("R1 walk1 reset", word, W'(1));
    mode = 4'd4; #1 chk("R1 walk0 reset", word, ~W'(1));
    mode = 4'd6; #1 chk("R1 count reset", word, '0);
    mode = 4'd7; #1 chk("R1 alt ones reset", word, '1);
    mode = 4'd5; #1 chk("R1 prng reset", word, W'(1));

    // R2: static modes and unused codes
    cval = 8'hA5;
    mode = 4'd0; #1 chk("R2 zeros", word, '0);
    mode = 4'd1; #1 chk("R2 ones", word, '1);
    mode = 4'd2; #1 chk("R2 const", word, 8'hA5);
    cval = 8'h3C; #1 chk("R2 const live", word, 8'h3C);
    for (int c = 9; c < 16; c++) begin
      mode = 4'(c); #1 chk("R2 unused code", word, '0);
    end

    // R4: walking one over more than two periods
    mode = 4'd3;
    do_init();
    for (int i = 0; i < 2 * W + 2; i++) begin
      chk("R4 walk1", word, W'(1) << (i % W));
      do_adv();
    end

    // R5: walking zero
    mode = 4'd4;
    do_init();
    for (int i = 0; i < 2 * W + 2; i++) begin
      chk("R5 walk0", word, ~(W'(1) << (i % W)));
      do_adv();
    end

    // R7: count across the full range and the wrap
    mode = 4'd6;
    do_init();
    for (int i = 0; i < N + 3; i++) begin
      chk("R7 count", word, W'(i % N));
      do_adv();
    end

    // R3: no strobe, output held
    hold = word;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 hold", word, hold);
    end

    // R8: ones/zeros alternation
    mode = 4'd7;
    do_init();
    for (int i = 0; i < 6; i++) begin
      chk("R8 alt ones", word, (i % 2 == 0) ? '1 : '0);
      do_adv();
    end

    // R9: constant/complement alternation, constant changed mid run
    mode = 4'd8; cval = 8'h5A;
    do_init();
    for (int i = 0; i < 6; i++) begin
      if (i == 3) begin
        cval = 8'hC3; #1;
      end
      chk("R9 alt const", word, (i % 2 == 0) ? cval : ~cval);
      do_adv();
    end

    // R6: full pseudo-random period from a nonzero seed
    mode = 4'd5; seed = 8'hB7;
    do_init();
    chk("R6 seed load", word, 8'hB7);
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    seen[8'hB7] = 1'b1;
    period = 0; distinct = 1;
    for (int i = 1; i <= N - 1; i++) begin
      do_adv();
      if (word == '0) chk("R6 nonzero", word, 8'h01);
      if (word == 8'hB7 && period == 0) period = i;
      if (!seen[word]) begin
        seen[word] = 1'b1;
        distinct++;
      end
    end
    chk_int("R6 period", period, N - 1);
    chk_int("R6 distinct words", distinct, N - 1);

    // R6: zero seed replaced by 1
    seed = '0;
    do_init();
    chk("R6 zero seed", word, W'(1));

    // R10: generators step while another mode is selected
    do_init();
    mode = 4'd0;
    for (int i = 0; i < 5; i++) do_adv();
    mode = 4'd6; #1 chk("R10 count stepped unselected", word, W'(5));
    mode = 4'd3; #1 chk("R10 walker stepped unselected", word, W'(1) << 5);
    mode = 4'd7; #1 chk("R10 alt phase stepped unselected", word, '0);

    // R10: init wins over advance in the same cycle
    mode = 4'd6;
    init = 1'b1; adv = 1'b1;
    step();
    init = 1'b0; adv = 1'b0;
    chk("R10 init over adv count", word, '0);
    mode = 4'd3; #1 chk("R10 init over adv walker", word, W'(1));

    finish_run();
  end

endmodule